// File: doc/BRIEF.md
# Dual-Enable Static Memory Cycle Controller

This block is a clock-sampled front end for a byte-wide static memory with a 17-bit address. It has two chip enables of opposite polarity and an active-low write strobe. On every rising clock edge it samples the address, the write data and the three control inputs. From them it decides whether the memory is deselected, in a read cycle or in a write cycle. A write is committed into an internal behavioural array only when the write condition ends. The block returns read data together with a drive flag. The flag stands in for the output buffer of a real part, so a low flag means high impedance.

The output is never driven during a write. This also covers a write strobe that is already low when the chip becomes selected, and an enable that drops before the strobe rises. The backing array is a parameterised window of the address space. Its low address bits select the word, and the upper bits alias onto the same words, which keeps the behavioural model small.

Top module: `sram_dual_ce_ctl`

## Requirements
- R1: The address input is 17 bits wide. The array holds 2^STORE_AW words (default STORE_AW = 6) and is indexed by address bits [STORE_AW-1:0]. Addresses that differ only above that field reach the same word.
- R2: A write is in progress on a sampled edge only when ce1_n = 0, ce2 = 1 and we_n = 0 are all true on that edge. Any other combination changes no stored word.
- R3: A write is committed on the first edge at which the write condition is false. It may end through ce1_n rising, ce2 falling or we_n rising. The commit uses the address and data sampled on the last edge at which the condition held.
- R4: After an edge that samples ce1_n = 0, ce2 = 1 and we_n = 1, dout_en is 1 and dout holds the stored word at the sampled address.
- R5: If we_n is low on or before the edge at which the chip becomes selected, dout_en stays 0 for the whole write.
- R6: If an enable goes inactive before we_n rises, or on the same edge, dout_en stays 0.
- R7: After an edge that samples ce1_n = 1 or ce2 = 0, dout_en is 0.
- R8: Whenever dout_en is 0, dout is 0.
- R9: An edge sampled with rst_n = 0 clears dout_en, dout and every stored word.
- R10: On the edge that ends a write through we_n rising while the chip stays selected, a read of the same address returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 17 | Word address |
| din | input | 8 | Write data |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write strobe, active low |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | Output drive flag (0 = high impedance) |

## Verification
The hardest case to reach is a write that a chip enable ends while we_n is still low. In that case the stored byte must be the one sampled on the last active edge and not the one present at the terminating edge, and the output must never turn on. The stimulus starts the write through the enable with the strobe already low. It then changes the data on the final active cycle and puts different data on the bus as ce1_n rises. A later read shows which byte was kept. A second sequence drops ce2 and raises we_n on the same edge.

// File: rtl/sram_dual_ce_ctl_pkg.sv
// Package: shared cycle states and the select decode for the dual-enable
// memory controller. Assumes active-low ce1 and active-high ce2.
package sram_dual_ce_ctl_pkg;

    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_state_t;

    // Chip is selected when both enables are in their active state.
    function automatic logic chip_sel(input logic ce1_n_i, input logic ce2_i);
        return (~ce1_n_i) & ce2_i;
    endfunction

    // Next cycle kind from one sampled set of controls.
    function automatic cyc_state_t next_cycle(input logic ce1_n_i,
                                              input logic ce2_i,
                                              input logic we_n_i);
        if (!chip_sel(ce1_n_i, ce2_i))
            return CYC_DESEL;
        else if (!we_n_i)
            return CYC_WRITE;
        else
            return CYC_READ;
    endfunction

endpackage

// File: rtl/sram_ctl_sequencer.sv
// Sequencer: tracks the cycle kind on each sampled edge, holds the address
// and data of the latest active write edge, and issues a one-edge commit
// when the write condition ends. Assumes all controls are synchronous.
module sram_ctl_sequencer
    import sram_dual_ce_ctl_pkg::*;
#(
    parameter int STORE_AW = 6,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STORE_AW-1:0] idx_in,
    input  logic [DATA_W-1:0]   din,
    input  logic                ce1_n,
    input  logic                ce2,
    input  logic                we_n,
    output logic                commit,
    output logic [STORE_AW-1:0] commit_idx,
    output logic [DATA_W-1:0]   commit_data,
    output logic                read_go
);

    cyc_state_t state_q;
    cyc_state_t state_d;

    // Decode the cycle kind that this edge will enter.
    always_comb begin
        state_d = next_cycle(ce1_n, ce2, we_n);
    end

    // A commit fires when a write was in progress and is no longer.
    always_comb begin
        commit  = (state_q == CYC_WRITE) && (state_d != CYC_WRITE);
        read_go = (state_d == CYC_READ);
    end

    // Cycle state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= CYC_DESEL;
        else
            state_q <= state_d;
    end

    // Hold the address and data of every active write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_idx  <= '0;
            commit_data <= '0;
        end else if (state_d == CYC_WRITE) begin
            commit_idx  <= idx_in;
            commit_data <= din;
        end
    end

endmodule

// File: rtl/sram_ctl_store.sv
// Store: behavioural word array, one register per word, with a decoded
// write enable and an asynchronous read port. Cleared by reset.
module sram_ctl_store #(
    parameter int STORE_AW = 6,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [STORE_AW-1:0] wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [STORE_AW-1:0] rd_idx,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int WORDS = 1 << STORE_AW;

    logic [DATA_W-1:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic hit;
        assign hit = wr_en && (wr_idx == STORE_AW'(w));

        // Word register: cleared on reset, loaded on a matching commit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[w] <= '0;
            else if (hit)
                words[w] <= wr_data;
        end
    end

    // Read port selects the addressed word.
    always_comb begin
        rd_data = words[rd_idx];
    end

endmodule

// File: rtl/sram_ctl_outstage.sv
// Output stage: registers the drive flag and the read byte. A commit to the
// word being read on the same edge is forwarded so the read sees new data.
// Data is forced to zero whenever the drive flag is low.
module sram_ctl_outstage #(
    parameter int STORE_AW = 6,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                read_go,
    input  logic [STORE_AW-1:0] rd_idx,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic                commit,
    input  logic [STORE_AW-1:0] commit_idx,
    input  logic [DATA_W-1:0]   commit_data,
    output logic [DATA_W-1:0]   dout,
    output logic                dout_en
);

    logic [DATA_W-1:0] fwd_data;

    // Pick the forwarded commit data when it targets the word being read.
    always_comb begin
        if (commit && (commit_idx == rd_idx))
            fwd_data = commit_data;
        else
            fwd_data = rd_data;
    end

    // Output registers for the drive flag and the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_en <= 1'b0;
            dout    <= '0;
        end else begin
            dout_en <= read_go;
            dout    <= read_go ? fwd_data : '0;
        end
    end

endmodule

// File: rtl/sram_dual_ce_ctl.sv
// Top: clock-sampled controller for a byte-wide static memory with two
// opposite-polarity chip enables and an active-low write strobe. The low
// STORE_AW address bits index the behavioural array and the upper bits alias.
module sram_dual_ce_ctl #(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int STORE_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              we_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic [STORE_AW-1:0] idx;
    logic                unused_hi;
    logic                commit;
    logic [STORE_AW-1:0] commit_idx;
    logic [DATA_W-1:0]   commit_data;
    logic                read_go;
    logic [DATA_W-1:0]   rd_data;

    // Split the address into the array index and the aliased upper part.
    assign idx       = addr[STORE_AW-1:0];
    assign unused_hi = ^addr[ADDR_W-1:STORE_AW];

    sram_ctl_sequencer #(.STORE_AW(STORE_AW), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx_in      (idx),
        .din         (din),
        .ce1_n       (ce1_n),
        .ce2         (ce2),
        .we_n        (we_n),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .read_go     (read_go)
    );

    sram_ctl_store #(.STORE_AW(STORE_AW), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  (commit_idx),
        .wr_data (commit_data),
        .rd_idx  (idx),
        .rd_data (rd_data)
    );

    sram_ctl_outstage #(.STORE_AW(STORE_AW), .DATA_W(DATA_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .read_go     (read_go),
        .rd_idx      (idx),
        .rd_data     (rd_data),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .dout        (dout),
        .dout_en     (dout_en)
    );

endmodule

// File: rtl/sram_dual_ce_ctl_chk.sv
// Checker: port-level properties of the controller, bound to the top.
module sram_dual_ce_ctl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce1_n,
    input logic              ce2,
    input logic              we_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    // R7
    deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n || !ce2) |=> !dout_en);

    // R5
    we_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n) |=> !dout_en);

    // R4
    read_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce1_n && ce2 && we_n) |=> dout_en);

    // R8
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!dout_en && dout == '0));

    // R6
    ce_drop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && (ce1_n || !ce2)) |=> !dout_en);

endmodule

bind sram_dual_ce_ctl sram_dual_ce_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .we_n    (we_n),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/sram_dual_ce_ctl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module sram_dual_ce_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic        ce1_n = 1'b1;
    logic        ce2 = 1'b0;
    logic        we_n = 1'b1;
    logic [7:0]  dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;

    sram_dual_ce_ctl u_sram_dual_ce_ctl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n),
        .dout(dout), .dout_en(dout_en)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one input set, let one edge sample it, settle after the edge.
    task automatic drive(input logic [16:0] a, input logic [7:0] d,
                         input logic c1, input logic c2, input logic w);
        addr = a; din = d; ce1_n = c1; ce2 = c2; we_n = w;
        @(posedge clk); #1;
    endtask

    task automatic expect_off(input string tag);
        chk(dout_en == 1'b0, tag, dout_en, 0);
        chk(dout == 8'h00, {tag, " data"}, dout, 0);
    endtask

    task automatic rd(input logic [16:0] a, input logic [7:0] e, input string tag);
        drive(a, 8'h00, 1'b0, 1'b1, 1'b1);
        chk(dout_en == 1'b1, {tag, " en"}, dout_en, 1);
        chk(dout == e, tag, dout, e);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(17'h0, 8'h0, 1'b1, 1'b0, 1'b1);
        drive(17'h0, 8'h0, 1'b1, 1'b0, 1'b1);
        expect_off("R9 reset outputs");
        rst_n = 1'b1;
        drive(17'h0, 8'h0, 1'b1, 1'b0, 1'b1);
        expect_off("R7 idle after reset");
    endtask

    task automatic t_we_term();
        rd(17'h5, 8'h00, "R4 read cleared word");
        drive(17'h5, 8'hA5, 1'b0, 1'b1, 1'b0);
        expect_off("R8 during write");
        drive(17'h5, 8'hA5, 1'b0, 1'b1, 1'b1);
        chk(dout_en == 1'b1, "R10 en after we rise", dout_en, 1);
        chk(dout == 8'hA5, "R10 forwarded byte", dout, 8'hA5);
        rd(17'h6, 8'h00, "R4 other word");
        rd(17'h5, 8'hA5, "R3 we-ended write");
    endtask

    task automatic t_ce1_term();
        drive(17'h7, 8'h11, 1'b1, 1'b1, 1'b0);
        expect_off("R7 deselected we low");
        drive(17'h7, 8'h3C, 1'b0, 1'b1, 1'b0);
        expect_off("R5 select with we low");
        drive(17'h7, 8'h3D, 1'b0, 1'b1, 1'b0);
        expect_off("R5 write continues");
        drive(17'h7, 8'h55, 1'b1, 1'b1, 1'b0);
        expect_off("R6 ce1 ends write");
        drive(17'h7, 8'h00, 1'b1, 1'b1, 1'b1);
        rd(17'h7, 8'h3D, "R3 last active sample kept");
    endtask

    task automatic t_ce2_same();
        rd(17'h8, 8'h00, "R4 before write");
        drive(17'h8, 8'h6E, 1'b0, 1'b1, 1'b0);
        drive(17'h8, 8'h6E, 1'b0, 1'b0, 1'b1);
        expect_off("R6 ce2 drop with we rise");
        rd(17'h8, 8'h6E, "R3 ce2-ended write");
    endtask

    task automatic t_no_write();
        drive(17'h9, 8'hFF, 1'b1, 1'b1, 1'b0);
        drive(17'h9, 8'hFF, 1'b0, 1'b0, 1'b0);
        drive(17'h9, 8'hFF, 1'b1, 1'b0, 1'b0);
        drive(17'h9, 8'hFF, 1'b0, 1'b0, 1'b1);
        expect_off("R7 ce2 low");
        rd(17'h9, 8'h00, "R2 partial conditions store nothing");
    endtask

    task automatic t_alias();
        drive(17'h10003, 8'h77, 1'b0, 1'b1, 1'b0);
        drive(17'h10003, 8'h77, 1'b0, 1'b1, 1'b1);
        rd(17'h00003, 8'h77, "R1 upper bits alias low");
        rd(17'h00043, 8'h77, "R1 bit6 aliases");
    endtask

    task automatic t_reset_clears();
        rst_n = 1'b0;
        drive(17'h5, 8'h00, 1'b0, 1'b1, 1'b1);
        expect_off("R9 reset over read");
        rst_n = 1'b1;
        rd(17'h5, 8'h00, "R9 word cleared");
        rd(17'h7, 8'h00, "R9 second word cleared");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_we_term();
        t_ce1_term();
        t_ce2_same();
        t_no_write();
        t_alias();
        t_reset_clears();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule